// File: doc/BRIEF.md
# Processor power mode controller

This block decides which clock domains of a processor core are running. Software asks for one of three static low-power states by writing a two-bit mode code. Doze stops the execution units, nap also stops snoop and bus logic, and sleep also stops the timebase. A static state is not entered at once. The controller first raises a quiesce request so that dispatch stops. It moves into the requested state only when every functional unit reports idle and no bus transaction is in flight. In any static state it raises an acknowledge output for the rest of the system. Its current state is visible on an encoded status output.

A separate dynamic gating enable works while the core is at full power. With it set, the clock enable of each functional unit drops whenever that unit is idle. The enable rises combinationally in the same cycle that the unit is handed work, so program timing and results do not change.

An interrupt wakes the core from any static state, and so does a decrementer event unless the core is in sleep, where only an interrupt or reset helps. Either wake also cancels an entry that is still waiting for quiet. Clock generation and voltage control lie outside this block.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, status is 0 (full power), every unit clock enable, the snoop enable and the timebase enable are 1, and acknowledge and quiesce request are 0.
- R2: A mode write with a nonzero code (1 = doze, 2 = nap, 3 = sleep) at full power raises quiesce request from the next cycle. Status stays 0 while any unit is busy or bus_busy is high.
- R3: While a request is pending, the first clock edge that sees all unit_idle bits high and bus_busy low sets status to the requested code. Quiesce request falls at the same edge.
- R4: The enables follow the status. In doze, unit enables are 0 and snoop and timebase are 1. In nap, unit and snoop enables are 0 and timebase is 1. In sleep, all are 0. Acknowledge is 1 exactly when status is nonzero.
- R5: At full power with dyn_gate_en high, unit_clk_en[i] equals !unit_idle[i] | unit_issue[i] in the same cycle.
- R6: At full power with dyn_gate_en low, every unit clock enable is 1 whatever unit_idle holds.
- R7: In doze or nap, irq or dec_evt returns status to 0 at the next clock edge.
- R8: In sleep, dec_evt alone has no effect; irq returns status to 0 at the next edge.
- R9: A mode write of code 0 while a request is pending cancels it, and the core stays at full power. Mode writes made while status is nonzero are ignored.
- R10: irq or dec_evt while a request is pending cancels the request, even if the core is quiet in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (free running) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_sel | input | 2 | Requested mode: 0 full, 1 doze, 2 nap, 3 sleep |
| dyn_gate_en | input | 1 | Enables per-unit idle clock gating |
| unit_idle | input | NUM_UNITS | Idle report from each functional unit |
| unit_issue | input | NUM_UNITS | Work handed to each unit in this cycle |
| bus_busy | input | 1 | A bus transaction is outstanding |
| irq | input | 1 | External interrupt wake |
| dec_evt | input | 1 | Decrementer event wake |
| unit_clk_en | output | NUM_UNITS | Clock enable per functional unit |
| snoop_clk_en | output | 1 | Clock enable of snoop and bus logic |
| tb_clk_en | output | 1 | Clock enable of the timebase |
| quiesce_req | output | 1 | Asks dispatch to drain before entry |
| pm_ack | output | 1 | Core is in a static low-power state |
| pm_state | output | 2 | Encoded current state |

## Verification
The bench sweeps all sixteen idle patterns against all sixteen issue patterns under dynamic gating. A design that gates on idle alone would starve a unit that receives work in the same cycle. For each target state it holds a unit busy and then the bus busy, to catch a design that enters before the core is quiet. It then checks the three enables, which a design with a mixed-up domain table would get wrong. Wakes are tried in every state, including a decrementer event in sleep, which must be ignored. A cancelled or wake-interrupted request must not later fire as a stale entry.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [1:0] {
      PM_FULL  = 2'd0,
      PM_DOZE  = 2'd1,
      PM_NAP   = 2'd2,
      PM_SLEEP = 2'd3
   } pm_state_e;
endpackage

// File: rtl/pm_fsm.sv
module pm_fsm
   import pm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [1:0] mode_sel,
   input  logic       all_quiet,
   input  logic       irq,
   input  logic       dec_evt,
   output pm_state_e  state,
   output logic       pending
);
   pm_state_e target;
   logic      wake_static;
   logic      wake_any;

   // sleep stops the timebase, so only an interrupt can leave it
   assign wake_any    = irq | dec_evt;
   assign wake_static = irq | (dec_evt & (state != PM_SLEEP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PM_FULL;
         target  <= PM_FULL;
         pending <= 1'b0;
      end else if (state != PM_FULL) begin
         if (wake_static) state <= PM_FULL;
      end else if (pending) begin
         if (wake_any || (mode_wr && mode_sel == 2'd0)) begin
            pending <= 1'b0;
         end else if (all_quiet) begin
            state   <= target;
            pending <= 1'b0;
         end
      end else if (mode_wr && mode_sel != 2'd0) begin
         pending <= 1'b1;
         target  <= pm_state_e'(mode_sel);
      end
   end
endmodule

// File: rtl/pm_domain_dec.sv
module pm_domain_dec
   import pm_pkg::*;
(
   input  pm_state_e state,
   output logic      core_run,
   output logic      snoop_en,
   output logic      tb_en,
   output logic      ack
);
   always_comb begin
      core_run = 1'b0;
      snoop_en = 1'b0;
      tb_en    = 1'b0;
      unique case (state)
         PM_FULL:  begin core_run = 1'b1; snoop_en = 1'b1; tb_en = 1'b1; end
         PM_DOZE:  begin snoop_en = 1'b1; tb_en = 1'b1; end
         PM_NAP:   tb_en = 1'b1;
         PM_SLEEP: ;
         default:  ;
      endcase
      ack = (state != PM_FULL);
   end
endmodule

// File: rtl/pm_unit_gate.sv
module pm_unit_gate (
   input  logic core_run,
   input  logic dyn_en,
   input  logic idle,
   input  logic issue,
   output logic clk_en
);
   // issue forces the enable combinationally so new work is never delayed
   assign clk_en = core_run & (~dyn_en | ~idle | issue);
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pm_pkg::*;
#(
   parameter int NUM_UNITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_wr,
   input  logic [1:0]           mode_sel,
   input  logic                 dyn_gate_en,
   input  logic [NUM_UNITS-1:0] unit_idle,
   input  logic [NUM_UNITS-1:0] unit_issue,
   input  logic                 bus_busy,
   input  logic                 irq,
   input  logic                 dec_evt,
   output logic [NUM_UNITS-1:0] unit_clk_en,
   output logic                 snoop_clk_en,
   output logic                 tb_clk_en,
   output logic                 quiesce_req,
   output logic                 pm_ack,
   output logic [1:0]           pm_state
);
   localparam int UNIT_MAX = 32;

   generate
      if (NUM_UNITS < 1 || NUM_UNITS > UNIT_MAX) begin : g_bad_cfg
         $error("pwr_mode_ctl: NUM_UNITS out of range");
      end
   endgenerate

   pm_state_e state;
   logic      pending;
   logic      core_run;
   logic      all_quiet;

   assign all_quiet = (&unit_idle) & ~bus_busy;

   pm_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .mode_sel  (mode_sel),
      .all_quiet (all_quiet),
      .irq       (irq),
      .dec_evt   (dec_evt),
      .state     (state),
      .pending   (pending)
   );

   pm_domain_dec u_dec (
      .state    (state),
      .core_run (core_run),
      .snoop_en (snoop_clk_en),
      .tb_en    (tb_clk_en),
      .ack      (pm_ack)
   );

   generate
      for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
         pm_unit_gate u_gate (
            .core_run (core_run),
            .dyn_en   (dyn_gate_en),
            .idle     (unit_idle[i]),
            .issue    (unit_issue[i]),
            .clk_en   (unit_clk_en[i])
         );
      end
   endgenerate

   assign quiesce_req = pending;
   assign pm_state    = state;
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
   parameter int NUM_UNITS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_UNITS-1:0] unit_idle,
   input logic [NUM_UNITS-1:0] unit_issue,
   input logic                 bus_busy,
   input logic                 irq,
   input logic                 dec_evt,
   input logic [NUM_UNITS-1:0] unit_clk_en,
   input logic                 snoop_clk_en,
   input logic                 tb_clk_en,
   input logic                 quiesce_req,
   input logic                 pm_ack,
   input logic [1:0]           pm_state
);
   p_sleep_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pm_state == 2'd3 |-> (unit_clk_en == '0 && !snoop_clk_en && !tb_clk_en && pm_ack));

   p_doze_domains_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pm_state == 2'd1 |-> (unit_clk_en == '0 && snoop_clk_en && tb_clk_en));

   p_entry_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state != 2'd0 && $past(pm_state) == 2'd0) |->
         $past((&unit_idle) && !bus_busy && quiesce_req));

   p_work_clocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pm_state == 2'd0 |-> ((unit_issue & ~unit_clk_en) == '0));

   p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pm_state == 2'd1 || pm_state == 2'd2) && (irq || dec_evt)) |=> pm_state == 2'd0);

   p_sleep_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state == 2'd3 && !irq) |=> pm_state == 2'd3);

   p_req_at_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      quiesce_req |-> pm_state == 2'd0);
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.NUM_UNITS(NUM_UNITS)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .unit_idle    (unit_idle),
   .unit_issue   (unit_issue),
   .bus_busy     (bus_busy),
   .irq          (irq),
   .dec_evt      (dec_evt),
   .unit_clk_en  (unit_clk_en),
   .snoop_clk_en (snoop_clk_en),
   .tb_clk_en    (tb_clk_en),
   .quiesce_req  (quiesce_req),
   .pm_ack       (pm_ack),
   .pm_state     (pm_state)
);

// File: tb/pwr_mode_ctl_tb_top.sv
module pwr_mode_ctl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NU = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wr = 1'b0;
   logic [1:0]    mode_sel = 2'd0;
   logic          dyn_gate_en = 1'b0;
   logic [NU-1:0] unit_idle = '0;
   logic [NU-1:0] unit_issue = '0;
   logic          bus_busy = 1'b0;
   logic          irq = 1'b0;
   logic          dec_evt = 1'b0;
   logic [NU-1:0] unit_clk_en;
   logic          snoop_clk_en, tb_clk_en, quiesce_req, pm_ack;
   logic [1:0]    pm_state;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctl #(.NUM_UNITS(NU)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
      .dyn_gate_en(dyn_gate_en), .unit_idle(unit_idle), .unit_issue(unit_issue),
      .bus_busy(bus_busy), .irq(irq), .dec_evt(dec_evt),
      .unit_clk_en(unit_clk_en), .snoop_clk_en(snoop_clk_en), .tb_clk_en(tb_clk_en),
      .quiesce_req(quiesce_req), .pm_ack(pm_ack), .pm_state(pm_state)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // enables expected for a given status code (R4)
   task automatic chk_domains(input string req, input int st);
      chk({req, " state"}, 32'(pm_state), 32'(st));
      chk({req, " units"}, 32'(unit_clk_en), (st == 0) ? 32'((1 << NU) - 1) : 32'd0);
      chk({req, " snoop"}, 32'(snoop_clk_en), 32'(st <= 1));
      chk({req, " tb"}, 32'(tb_clk_en), 32'(st != 3));
      chk({req, " ack"}, 32'(pm_ack), 32'(st != 0));
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // request a state while busy, then release quiet
   task automatic enter(input int tgt);
      @(negedge clk);
      unit_idle = '0; bus_busy = 1'b0; mode_wr = 1'b1; mode_sel = 2'(tgt);
      step();
      mode_wr = 1'b0;
      chk("R2 qreq raised", 32'(quiesce_req), 32'd1);
      step();
      chk("R2 busy unit holds full", 32'(pm_state), 32'd0);
      @(negedge clk);
      unit_idle = '1; bus_busy = 1'b1;
      step();
      chk("R2 busy bus holds full", 32'(pm_state), 32'd0);
      @(negedge clk);
      bus_busy = 1'b0;
      step();
      chk("R3 entered target", 32'(pm_state), 32'(tgt));
      chk("R3 qreq dropped", 32'(quiesce_req), 32'd0);
      chk_domains("R4", tgt);
   endtask

   task automatic run();
      #(CLK_PERIOD * 2 + 1);
      chk_domains("R1 reset", 0);
      chk("R1 qreq", 32'(quiesce_req), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 and R6 sweeps
      bus_busy = 1'b1;
      for (int idl = 0; idl < 16; idl++) begin
         for (int iss = 0; iss < 16; iss++) begin
            @(negedge clk);
            dyn_gate_en = 1'b1; unit_idle = NU'(idl); unit_issue = NU'(iss);
            #1;
            chk("R5 dyn gate", 32'(unit_clk_en), 32'((~idl | iss) & 15));
         end
         @(negedge clk);
         dyn_gate_en = 1'b0;
         #1;
         chk("R6 dyn off", 32'(unit_clk_en), 32'd15);
      end
      unit_issue = '0;

      // every static state, woken by irq or by decrementer
      for (int tgt = 1; tgt <= 3; tgt++) begin
         for (int src = 0; src < 2; src++) begin
            enter(tgt);
            @(negedge clk);
            mode_wr = 1'b1; mode_sel = 2'd0;
            step();
            mode_wr = 1'b0;
            chk("R9 write ignored in static", 32'(pm_state), 32'(tgt));
            if (tgt == 3) begin
               @(negedge clk);
               dec_evt = 1'b1;
               step();
               chk("R8 dec ignored in sleep", 32'(pm_state), 32'd3);
               @(negedge clk);
               dec_evt = 1'b0; irq = 1'b1;
               step();
               chk("R8 irq wakes sleep", 32'(pm_state), 32'd0);
            end else begin
               @(negedge clk);
               if (src == 0) irq = 1'b1; else dec_evt = 1'b1;
               step();
               chk("R7 wake", 32'(pm_state), 32'd0);
            end
            @(negedge clk);
            irq = 1'b0; dec_evt = 1'b0;
            #1;
            chk_domains("R7 back full", 0);
         end
      end

      // R9 cancel by writing 0
      @(negedge clk);
      unit_idle = '0; mode_wr = 1'b1; mode_sel = 2'd2;
      step();
      @(negedge clk);
      mode_sel = 2'd0;
      step();
      mode_wr = 1'b0;
      chk("R9 cancel qreq", 32'(quiesce_req), 32'd0);
      @(negedge clk);
      unit_idle = '1;
      step(); step();
      chk("R9 no stale entry", 32'(pm_state), 32'd0);

      // R10 wake while pending and quiet
      for (int src = 0; src < 2; src++) begin
         @(negedge clk);
         unit_idle = '0; mode_wr = 1'b1; mode_sel = 2'd1;
         step();
         @(negedge clk);
         mode_wr = 1'b0; unit_idle = '1;
         if (src == 0) irq = 1'b1; else dec_evt = 1'b1;
         step();
         chk("R10 wake cancels entry", 32'(pm_state), 32'd0);
         chk("R10 qreq cleared", 32'(quiesce_req), 32'd0);
         @(negedge clk);
         irq = 1'b0; dec_evt = 1'b0;
         step();
         chk("R10 stays full", 32'(pm_state), 32'd0);
      end
   endtask

   initial begin
      fork
         run();
         begin
            repeat (100000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule